// File: doc/BRIEF.md
# Split Carry-Select Adder

This block adds two N-bit unsigned operands and a carry-in, and returns an N-bit sum with a carry-out. It is purely combinational. The operand width is cut into a lower section and an upper section at a parameterised boundary. The lower section is a plain ripple adder. Its carry-out arrives late, and the upper section does not wait for it.

The upper section forms bitwise propagate (XOR) and generate (AND) terms once. Two carry chains share those terms: one assumes a carry of 0 into the section and the other assumes 1. The real carry from the lower section then selects a whole carry vector. The upper sum bits are each propagate term XORed with the selected carry into that bit. The carry-out is the top entry of the selected vector.

Only the upper bits are duplicated, so the extra hardware is one carry chain and one multiplexer. Subtraction follows the usual pattern: invert the subtrahend and set the carry-in.

Top module: `csel_adder`

## Requirements
- R1: For every input, the concatenation {cout, sum} equals a + b + cin as an (N+1)-bit unsigned value.
- R2: Sum bits below LOW_W equal the low LOW_W bits of a[LOW_W-1:0] + b[LOW_W-1:0] + cin, whatever the upper operand bits are.
- R3: When the lower section produces no carry, sum[N-1:LOW_W] equals the low N-LOW_W bits of a[N-1:LOW_W] + b[N-1:LOW_W].
- R4: When the lower section produces a carry, sum[N-1:LOW_W] equals the low N-LOW_W bits of a[N-1:LOW_W] + b[N-1:LOW_W] + 1.
- R5: cout is 1 exactly when the upper-section addition, including the selected carry from below, overflows N-LOW_W bits.
- R6: With a all ones, b zero and cin 1, a carry ripples through the whole width across the boundary, so sum is 0 and cout is 1. With cin 0, sum equals a and cout is 0.
- R7: Driving b with ~x and cin with 1 gives sum = a - x modulo 2^N, and cout = 1 exactly when a >= x (unsigned).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
An 8-bit copy with the boundary at bit 3 is swept over every combination of a, b and cin. This exercises every lower-carry outcome against every upper propagate/generate pattern, so a wrong choice of chain, a swapped assumption or a broken per-bit sum shows up as a difference in the upper bits alone (R3, R4). The lower bits are compared on their own, which separates a fault in the shared lower adder from one in the selection path.

A 32-bit copy receives pseudo-random operands to cover long carry chains on both sides of the boundary. It also receives directed all-ones plus carry-in cases, which reach the full-ripple corner (R6). Subtraction patterns with equal, larger and smaller minuends check the borrow sense of cout (R7).

// File: rtl/csel_pkg.sv
package csel_pkg;
    // Carry value an upper-section chain is built to assume
    typedef enum logic {
        ASSUME_ZERO = 1'b0,
        ASSUME_ONE  = 1'b1
    } carry_assume_e;
endpackage

// File: rtl/csel_pg_setup.sv
module csel_pg_setup #(
    parameter int W = 16
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    output logic [W-1:0] prop,
    output logic [W-1:0] gen
);
    // XOR-form propagate is kept so it doubles as the half-sum
    always_comb begin
        prop = op_x ^ op_y;
        gen  = op_x & op_y;
    end
endmodule

// File: rtl/csel_carry_chain.sv
module csel_carry_chain #(
    parameter int W = 16
) (
    input  logic         c_in,
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    output logic [W:0]   carry
);
    assign carry[0] = c_in;
    for (genvar i = 0; i < W; i++) begin : g_stage
        assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
    end
endmodule

// File: rtl/csel_low_adder.sv
module csel_low_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic         c_in,
    output logic [W-1:0] s,
    output logic         c_out
);
    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [W:0]   carry;

    csel_pg_setup #(.W(W)) u_pg (
        .op_x (op_x),
        .op_y (op_y),
        .prop (prop),
        .gen  (gen)
    );

    csel_carry_chain #(.W(W)) u_chain (
        .c_in  (c_in),
        .prop  (prop),
        .gen   (gen),
        .carry (carry)
    );

    assign s     = prop ^ carry[W-1:0];
    assign c_out = carry[W];
endmodule

// File: rtl/csel_adder.sv
module csel_adder
    import csel_pkg::*;
#(
    parameter int N     = 32,
    parameter int LOW_W = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);
    localparam int HI_W = N - LOW_W;

    // Boundary must leave at least one bit on each side
    initial begin
        if (LOW_W < 1 || LOW_W >= N)
            $error("csel_adder: LOW_W must satisfy 0 < LOW_W < N");
    end

    typedef struct packed {
        logic [HI_W:0]   carry_sel;
        logic [HI_W-1:0] sum_hi;
        logic            carry_top;
    } hi_res_t;

    logic [LOW_W-1:0] sum_lo;
    logic             carry_lo;
    logic [HI_W-1:0]  prop_hi;
    logic [HI_W-1:0]  gen_hi;
    logic [HI_W:0]    carry_c0;
    logic [HI_W:0]    carry_c1;
    hi_res_t          hi_d;

    // Lower section: single shared adder
    csel_low_adder #(.W(LOW_W)) u_low (
        .op_x  (a[LOW_W-1:0]),
        .op_y  (b[LOW_W-1:0]),
        .c_in  (cin),
        .s     (sum_lo),
        .c_out (carry_lo)
    );

    // Upper section: one P/G setup shared by both chains
    csel_pg_setup #(.W(HI_W)) u_pg_hi (
        .op_x (a[N-1:LOW_W]),
        .op_y (b[N-1:LOW_W]),
        .prop (prop_hi),
        .gen  (gen_hi)
    );

    csel_carry_chain #(.W(HI_W)) u_chain_c0 (
        .c_in  (ASSUME_ZERO),
        .prop  (prop_hi),
        .gen   (gen_hi),
        .carry (carry_c0)
    );

    csel_carry_chain #(.W(HI_W)) u_chain_c1 (
        .c_in  (ASSUME_ONE),
        .prop  (prop_hi),
        .gen   (gen_hi),
        .carry (carry_c1)
    );

    // Select the carry vector, then generate the sum from it
    always_comb begin
        hi_d.carry_sel = carry_lo ? carry_c1 : carry_c0;
        hi_d.sum_hi    = prop_hi ^ hi_d.carry_sel[HI_W-1:0];
        hi_d.carry_top = hi_d.carry_sel[HI_W];
    end

    assign sum  = {hi_d.sum_hi, sum_lo};
    assign cout = hi_d.carry_top;
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
    parameter int N     = 32,
    parameter int LOW_W = 16
) (
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         cin,
    input logic [N-1:0] sum,
    input logic         cout
);
    localparam int HI_W = N - LOW_W;

    logic [N:0]      full_ref;
    logic [LOW_W:0]  lo_ref;
    logic [HI_W:0]   hi_ref;
    logic            known;

    always_comb begin
        known    = !$isunknown({a, b, cin, sum, cout});
        full_ref = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
        lo_ref   = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
        hi_ref   = {1'b0, a[N-1:LOW_W]} + {1'b0, b[N-1:LOW_W]}
                   + {{HI_W{1'b0}}, lo_ref[LOW_W]};
    end

    always_comb begin
        if (known) begin
            AST_FULL_SUM: assert ({cout, sum} == full_ref); // R1
            AST_LOW_SUM: assert (sum[LOW_W-1:0] == lo_ref[LOW_W-1:0]); // R2
            AST_HIGH_NO_CARRY: assert (lo_ref[LOW_W] || sum[N-1:LOW_W] == hi_ref[HI_W-1:0]); // R3
            AST_HIGH_CARRY: assert (!lo_ref[LOW_W] || sum[N-1:LOW_W] == hi_ref[HI_W-1:0]); // R4
            AST_CARRY_OUT: assert (cout == hi_ref[HI_W]); // R5
            AST_FULL_RIPPLE: assert (!(a == '1 && b == '0 && cin) || (sum == '0 && cout)); // R6
        end
    end
endmodule

bind csel_adder csel_adder_chk #(.N(N), .LOW_W(LOW_W)) u_csel_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/csel_adder_bench.sv
`timescale 1ns/1ps
module csel_adder_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk; // 250 MHz

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Small configuration: exhaustive sweep
    logic [7:0]  sa, sb, ss;
    logic        sc, sco;
    // Full-width configuration: random and directed
    logic [31:0] wa, wb, ws;
    logic        wc, wco;

    csel_adder #(.N(8), .LOW_W(3)) u_csel_adder (
        .a(sa), .b(sb), .cin(sc), .sum(ss), .cout(sco)
    );

    csel_adder #(.N(32), .LOW_W(12)) u_csel_adder_w (
        .a(wa), .b(wb), .cin(wc), .sum(ws), .cout(wco)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            if (n_bad < 20)
                $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_w(input logic [31:0] x, input logic [31:0] y, input logic c);
        wa = x; wb = y; wc = c;
        #1;
    endtask

    task automatic check_w_full(input string req);
        logic [32:0] e;
        e = {1'b0, wa} + {1'b0, wb} + {32'd0, wc};
        chk(req, {31'd0, wco, ws}, {31'd0, e});
    endtask

    initial begin
        sa = '0; sb = '0; sc = 1'b0;
        wa = '0; wb = '0; wc = 1'b0;
        #1;
        // Zero inputs give zero result (R1)
        chk("R1 zero", {55'd0, sco, ss}, 64'd0);

        // Exhaustive 8-bit sweep, boundary at bit 3
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    int lo, hi, tot;
                    sa = 8'(ai); sb = 8'(bi); sc = ci[0];
                    #1;
                    tot = ai + bi + ci;
                    lo  = (ai % 8) + (bi % 8) + ci;
                    hi  = (ai / 8) + (bi / 8) + (lo / 8);
                    chk("R1", {55'd0, sco, ss}, 64'(tot));
                    chk("R2", {61'd0, ss[2:0]}, 64'(lo % 8));
                    if (lo < 8)
                        chk("R3", {59'd0, ss[7:3]}, 64'(hi % 32));
                    else
                        chk("R4", {59'd0, ss[7:3]}, 64'(hi % 32));
                    chk("R5", {63'd0, sco}, 64'(hi / 32));
                end
            end
        end

        // 8-bit full ripple corner
        sa = 8'hFF; sb = 8'h00; sc = 1'b1; #1;
        chk("R6 ripple8", {55'd0, sco, ss}, 64'h100);
        sc = 1'b0; #1;
        chk("R6 noripple8", {55'd0, sco, ss}, 64'h0FF);

        // Random 32-bit vectors
        for (int k = 0; k < 3000; k++) begin
            drive_w($urandom, $urandom, 1'($urandom));
            check_w_full("R1 random32");
        end

        // Long chains straddling the boundary at bit 12
        drive_w(32'hFFFF_FFFF, 32'h0, 1'b1);
        chk("R6 ripple32", {31'd0, wco, ws}, {31'd0, 33'h1_0000_0000});
        drive_w(32'hFFFF_FFFF, 32'h0, 1'b0);
        chk("R6 noripple32", {31'd0, wco, ws}, {31'd0, 33'h0_FFFF_FFFF});
        drive_w(32'h0000_0FFF, 32'h0000_0001, 1'b0);
        chk("R4 boundary carry", {32'd0, ws}, 64'h0000_1000);
        drive_w(32'hFFFF_F000, 32'h0000_0FFF, 1'b0);
        chk("R3 no boundary carry", {31'd0, wco, ws}, {31'd0, 33'h0_FFFF_FFFF});
        drive_w(32'hFFFF_F000, 32'h0000_0FFF, 1'b1);
        chk("R5 carry out via select", {31'd0, wco, ws}, {31'd0, 33'h1_0000_0000});
        drive_w(32'h1234_5000, 32'h0000_0ABC, 1'b0);
        drive_w(32'hABCD_E123, 32'h0000_0000, 1'b0);
        chk("R2 low only", {52'd0, ws[11:0]}, 64'h123);
        drive_w(32'h0000_0123, 32'hFFFF_F000, 1'b0);
        chk("R2 high ignored", {52'd0, ws[11:0]}, 64'h123);

        // Subtraction: a + ~x + 1
        drive_w(32'd1000, ~32'd1000, 1'b1);
        chk("R7 equal", {31'd0, wco, ws}, {31'd0, 33'h1_0000_0000});
        drive_w(32'd5000, ~32'd1234, 1'b1);
        chk("R7 larger", {31'd0, wco, ws}, {31'd0, 1'b1, 32'd3766});
        drive_w(32'd7, ~32'd9, 1'b1);
        chk("R7 smaller", {31'd0, wco, ws}, {31'd0, 1'b0, 32'hFFFF_FFFE});
        for (int k = 0; k < 500; k++) begin
            logic [31:0] x, y;
            x = $urandom; y = $urandom;
            drive_w(x, ~y, 1'b1);
            chk("R7 random", {31'd0, wco, ws}, {31'd0, (x >= y), x - y});
        end

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule